// File: doc/BRIEF.md
# ADC Conversion Controller

This block is the register-side controller for an 8-bit successive-approximation analog-to-digital converter on a small microcontroller bus. Software sees two byte-wide registers. One is a control/status register holding interrupt enable, end-of-conversion, start, converter power and an oscillator-off bit. The other is a read-only result register. A write that requests a start makes the block run a binary search over the converter code, one bit per step, MSB first. When the search ends, the block publishes the result, raises end-of-conversion and, if enabled, holds an interrupt request.

The analog comparator lives outside the block. The controller drives its current trial code on `dac_code`. The comparator answers on `cmp_ge`, which reads 1 when the analog input is at or above that code. End-of-conversion comes out of reset at 1 and software cannot clear it. Only an accepted start clears it. A start issued mid-conversion throws the running search away and begins again. The oscillator-off bit is only stored and exported; it does not affect the converter.

Top module: `adc_ctrl`

## Requirements
- R1: Offset 1 (`bus_addr`=1) selects the control/status register and offset 0 the result register. The result register resets to 0x00, and bus writes to offset 0 change nothing.
- R2: Control/status reads return interrupt enable on bit 7, end-of-conversion on bit 6, power-on on bit 4 and oscillator-off on bit 2. Bits 5, 3, 1 and 0 always read 0. The value after reset is 0x40.
- R3: Writing 0 to bit 6 leaves end-of-conversion unchanged. It falls only in the cycle after an accepted start.
- R4: A control write with bit 5 = 1 and bit 4 = 1 is an accepted start: from the next cycle end-of-conversion reads 0. Bit 5 always reads 0.
- R5: Result and end-of-conversion update exactly 8 x STEP_CYCLES clock edges after the edge that accepted the start. The result is the largest code that `cmp_ge` reports at or below the input.
- R6: An accepted start during a conversion discards it and restarts. Completion then comes 8 x STEP_CYCLES edges after the latest start.
- R7: `irq` is 1 exactly while interrupt enable and end-of-conversion are both 1.
- R8: A control write with bit 4 = 0 starts nothing and leaves end-of-conversion unchanged. If a conversion is running, that write aborts it: end-of-conversion stays 0, the result stays unchanged and `dac_code` returns to 0.
- R9: `osc_off` follows bit 2 of the control/status register and has no effect on conversions.
- R10: `dac_code` is 0 when no conversion runs. During a step it shows the bits already decided plus the current trial bit, so the first step shows 0x80.
- R11: The result register changes only on the edge where end-of-conversion rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 result, 1 control/status |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| cmp_ge | input | 1 | Comparator: analog input at or above `dac_code` |
| dac_code | output | 8 | Trial code for the comparator |
| irq | output | 1 | Level interrupt request |
| osc_off | output | 1 | Stored oscillator-off control |

## Verification
The bench models an analog level as an integer and answers `cmp_ge` from it. Conversions run at mid-scale and patterned codes, and at 0x00 and 0xFF, which catches a trial bit that is kept or dropped wrongly at either end. A start issued in mid-conversion with a changed level shows whether the first search was truly discarded and whether timing counts from the second start. Starts without power, power removal mid-conversion, and writes of 0 to the end-of-conversion bit or to the result offset separate real control paths from bits that are only stored. The bench also counts the edge of completion and follows the trial code step by step.

// File: rtl/adc_ctrl_pkg.sv
// Shared register selects and control/status bit positions for the
// conversion controller. Assumes an 8-bit bus and one address bit.
package adc_ctrl_pkg;
    localparam int DATA_W = 8;

    typedef enum logic {
        SEL_RESULT = 1'b0,
        SEL_CTRL   = 1'b1
    } reg_sel_e;

    localparam int BIT_IE    = 7;
    localparam int BIT_EOC   = 6;
    localparam int BIT_START = 5;
    localparam int BIT_PWR   = 4;
    localparam int BIT_OSC   = 2;

    // bits kept in the control image (everything except eoc and start)
    localparam logic [DATA_W-1:0] STORE_MASK = 8'b1001_1111;
    // bits visible on read from the stored image
    localparam logic [DATA_W-1:0] READ_MASK  = 8'b1001_0100;
endpackage

// File: rtl/adc_ctl_reg.sv
// Control/status register. Holds the writable image and the
// end-of-conversion flag, and decodes start and abort requests from a
// write. Assumes wr_ctrl lasts one cycle per write and that the
// sequencer never reports done in a cycle with start or abort.
module adc_ctl_reg
    import adc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              conv_done,
    output logic [DATA_W-1:0] img,
    output logic              eoc,
    output logic              start_go,
    output logic              abort
);
    logic [DATA_W-1:0] img_q;
    logic              eoc_q;

    // accepted start needs the power bit set in the same write
    assign start_go = wr_ctrl & wdata[BIT_START] & wdata[BIT_PWR];
    assign abort    = wr_ctrl & ~wdata[BIT_PWR];

    // stored image of the writable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q <= '0;
        end else if (wr_ctrl) begin
            img_q <= wdata & STORE_MASK;
        end
    end

    // end-of-conversion: cleared by a start, set by the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_q <= 1'b1;
        end else if (start_go) begin
            eoc_q <= 1'b0;
        end else if (conv_done) begin
            eoc_q <= 1'b1;
        end
    end

    assign img = img_q;
    assign eoc = eoc_q;
endmodule

// File: rtl/adc_sar_seq.sv
// Successive-approximation sequencer. Walks RES_W trial bits MSB first,
// spending STEP_CYCLES clocks on each. It keeps a bit when cmp_ge is high
// on the last clock of its step. A start takes priority over an abort,
// and both over a completion.
module adc_sar_seq #(
    parameter int RES_W       = 8,
    parameter int STEP_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             abort,
    input  logic             cmp_ge,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam int DIV_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(RES_W - 1);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [DIV_W-1:0] div_q;
    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] trial;
    logic             step_end;
    logic             last_step;

    assign trial     = acc_q | (RES_W'(1) << idx_q);
    assign step_end  = busy_q && (div_q == DIV_LAST);
    assign last_step = step_end && (idx_q == '0);
    assign done      = last_step && !go && !abort;

    // search state: restart, abort, or advance one clock of a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            div_q  <= '0;
            acc_q  <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            idx_q  <= IDX_TOP;
            div_q  <= '0;
            acc_q  <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            div_q  <= '0;
            acc_q  <= '0;
        end else if (step_end) begin
            div_q <= '0;
            if (cmp_ge) begin
                acc_q <= trial;
            end
            if (idx_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q - IDX_W'(1);
            end
        end else if (busy_q) begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // result register: loaded only on a completing step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (done) begin
            res_q <= cmp_ge ? trial : acc_q;
        end
    end

    assign busy     = busy_q;
    assign dac_code = busy_q ? trial : '0;
    assign result   = res_q;
endmodule

// File: rtl/adc_rd_mux.sv
// Read-data multiplexer. Places the end-of-conversion flag into the
// masked control image, or returns the result, by register select.
module adc_rd_mux
    import adc_ctrl_pkg::*;
(
    input  logic              sel,
    input  logic [DATA_W-1:0] img,
    input  logic              eoc,
    input  logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] ctrl_view;

    // control view: visible stored bits plus the live flag
    always_comb begin
        ctrl_view          = img & READ_MASK;
        ctrl_view[BIT_EOC] = eoc;
    end

    // register select
    always_comb begin
        if (reg_sel_e'(sel) == SEL_CTRL) begin
            rdata = ctrl_view;
        end else begin
            rdata = result;
        end
    end
endmodule

// File: rtl/adc_ctrl.sv
// Top of the conversion controller: register file, sequencer and read
// path. Assumes single-cycle write strobes and a comparator answer that
// is valid in the same cycle as dac_code.
module adc_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int STEP_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmp_ge,
    output logic [DATA_W-1:0] dac_code,
    output logic              irq,
    output logic              osc_off
);
    logic              wr_ctrl;
    logic [DATA_W-1:0] img_w;
    logic              eoc_w;
    logic              pwr_w;
    logic              start_go;
    logic              abort;
    logic              seq_busy;
    logic              seq_done;
    logic [DATA_W-1:0] result_w;

    assign wr_ctrl = bus_we && (reg_sel_e'(bus_addr) == SEL_CTRL);

    adc_ctl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wdata    (bus_wdata),
        .conv_done(seq_done),
        .img      (img_w),
        .eoc      (eoc_w),
        .start_go (start_go),
        .abort    (abort)
    );

    adc_sar_seq #(
        .RES_W      (DATA_W),
        .STEP_CYCLES(STEP_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (start_go),
        .abort   (abort),
        .cmp_ge  (cmp_ge),
        .busy    (seq_busy),
        .done    (seq_done),
        .dac_code(dac_code),
        .result  (result_w)
    );

    adc_rd_mux u_rd (
        .sel   (bus_addr),
        .img   (img_w),
        .eoc   (eoc_w),
        .result(result_w),
        .rdata (bus_rdata)
    );

    assign pwr_w   = img_w[BIT_PWR];
    assign irq     = img_w[BIT_IE] & eoc_w;
    assign osc_off = img_w[BIT_OSC];
endmodule

// File: rtl/adc_ctrl_chk.sv
// Protocol checker for the conversion controller, bound to the top.
module adc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_addr,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic [7:0] dac_code,
    input logic       eoc_w,
    input logic       pwr_w,
    input logic       seq_busy,
    input logic [7:0] result_w
);
    logic start_wr;
    assign start_wr = bus_we && bus_addr && bus_wdata[5] && bus_wdata[4];

    a_r4_start_clears_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> !eoc_w);

    a_r3_eoc_falls_only_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_w) |-> $past(start_wr));

    a_r10_first_trial_msb: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (dac_code == 8'h80));

    a_r11_result_moves_with_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_w) |-> $rose(eoc_w));

    a_r8_off_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_w |-> (dac_code == 8'h00));

    a_r5_eoc_after_search: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_w) |-> $past(seq_busy));
endmodule

bind adc_ctrl adc_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .dac_code (dac_code),
    .eoc_w    (eoc_w),
    .pwr_w    (pwr_w),
    .seq_busy (seq_busy),
    .result_w (result_w)
);

// File: tb/adc_ctrl_bench.sv
`timescale 1ns/1ps
module adc_ctrl_bench;
    localparam int STEP = 2;
    localparam int CONV = 8 * STEP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b1;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cmp_ge;
    logic [7:0] dac_code;
    logic       irq;
    logic       osc_off;
    int         vin = 0;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    assign cmp_ge = (int'(dac_code) <= vin);

    adc_ctrl #(.STEP_CYCLES(STEP)) u_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_ge(cmp_ge),
        .dac_code(dac_code), .irq(irq), .osc_off(osc_off)
    );

    // behavioural reference state
    bit m_ie, m_eoc, m_pwr, m_osc, m_busy;
    int m_res, m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ie = 0; m_eoc = 1; m_pwr = 0; m_osc = 0; m_busy = 0;
            m_res = 0; m_cnt = 0;
        end else begin
            if (bus_we && bus_addr) begin
                m_ie = bus_wdata[7]; m_pwr = bus_wdata[4]; m_osc = bus_wdata[2];
            end
            if (bus_we && bus_addr && bus_wdata[5] && bus_wdata[4]) begin
                m_busy = 1; m_cnt = CONV; m_eoc = 0;
            end else if (bus_we && bus_addr && !bus_wdata[4]) begin
                m_busy = 0;
            end else if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_eoc = 1; m_res = vin;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            int exp_rd;
            exp_rd = bus_addr ? {m_ie, m_eoc, 1'b0, m_pwr, 1'b0, m_osc, 2'b00} : m_res;
            chk(bus_rdata == 8'(exp_rd), bus_addr ? "R2 ctrl read" : "R1 result read",
                bus_rdata, exp_rd);
            chk(irq == (m_ie & m_eoc), "R7 irq", irq, m_ie & m_eoc);
            chk(osc_off == m_osc, "R9 osc_off", osc_off, m_osc);
            if (!m_busy) chk(dac_code == 8'h00, "R10 idle dac", dac_code, 0);
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = 1'b1;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        bus_addr = a; #0.5; v = bus_rdata; #0.5;
    endtask

    bit done_flag = 0;
    initial begin
        #(200000 * 5.0);
        if (!done_flag) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run ended)");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // reset state
        rd(1'b1, v); chk(v == 8'h40, "R2 reset value", v, 8'h40);
        rd(1'b0, v); chk(v == 8'h00, "R1 result reset", v, 0);
        chk(irq == 1'b0, "R7 irq at reset", irq, 0);
        // enable with eoc already high
        wr(1'b1, 8'h90);
        rd(1'b1, v); chk(v == 8'hD0, "R2 ie/pwr read", v, 8'hD0);
        chk(irq == 1'b1, "R7 irq ie&eoc", irq, 1);
        wr(1'b1, 8'h10);
        chk(irq == 1'b0, "R7 irq cleared by ie", irq, 0);
        // eoc written 0, reserved bits written 1
        wr(1'b1, 8'h1F);
        rd(1'b1, v); chk(v == 8'h54, "R3 eoc kept, R2 reserved read 0", v, 8'h54);
        chk(osc_off == 1'b1, "R9 osc_off set", osc_off, 1);
        // write to result offset
        wr(1'b0, 8'hAA);
        rd(1'b0, v); chk(v == 8'h00, "R1 result write ignored", v, 0);
        // basic conversion with step trace
        vin = 8'hA5;
        wr(1'b1, 8'h30);
        rd(1'b1, v); chk(v == 8'h10, "R4 start clears eoc, start reads 0", v, 8'h10);
        chk(dac_code == 8'h80, "R10 first trial", dac_code, 8'h80);
        cyc(STEP);
        chk(dac_code == 8'hC0, "R10 second trial", dac_code, 8'hC0);
        cyc(CONV - STEP - 1);
        rd(1'b1, v); chk(v[6] == 1'b0, "R5 eoc not early", v[6], 0);
        rd(1'b0, v); chk(v == 8'h00, "R11 result held mid-conversion", v, 0);
        cyc(1);
        rd(1'b1, v); chk(v[6] == 1'b1, "R5 eoc on time", v[6], 1);
        rd(1'b0, v); chk(v == 8'hA5, "R5 result", v, 8'hA5);
        // boundaries, with osc_off set
        vin = 8'hFF;
        wr(1'b1, 8'h34); cyc(CONV);
        rd(1'b0, v); chk(v == 8'hFF, "R5 full scale, R9 no effect", v, 8'hFF);
        vin = 0;
        wr(1'b1, 8'h30); cyc(CONV);
        rd(1'b0, v); chk(v == 8'h00, "R5 zero scale", v, 0);
        // restart mid-conversion
        vin = 8'h3C;
        wr(1'b1, 8'h30); cyc(5);
        vin = 8'h77;
        wr(1'b1, 8'h30); cyc(CONV - 1);
        rd(1'b1, v); chk(v[6] == 1'b0, "R6 restart timing", v[6], 0);
        cyc(1);
        rd(1'b0, v); chk(v == 8'h77, "R6 restart result", v, 8'h77);
        // start without power
        wr(1'b1, 8'h20); cyc(CONV + 2);
        rd(1'b1, v); chk(v == 8'h40, "R8 unpowered start ignored", v, 8'h40);
        chk(dac_code == 8'h00, "R8 no search", dac_code, 0);
        // power removed mid-conversion
        wr(1'b1, 8'h10);
        vin = 8'h12;
        wr(1'b1, 8'h30); cyc(3);
        wr(1'b1, 8'h00);
        chk(dac_code == 8'h00, "R8 abort idles dac", dac_code, 0);
        cyc(CONV + 2);
        rd(1'b1, v); chk(v == 8'h00, "R8 abort leaves eoc 0", v, 0);
        rd(1'b0, v); chk(v == 8'h77, "R8 abort keeps result", v, 8'h77);
        // interrupt raised on completion
        wr(1'b1, 8'h90);
        chk(irq == 1'b0, "R7 no irq while eoc 0", irq, 0);
        vin = 8'h40;
        wr(1'b1, 8'hB0); cyc(CONV);
        chk(irq == 1'b1, "R7 irq on completion", irq, 1);
        rd(1'b0, v); chk(v == 8'h40, "R5 result 0x40", v, 8'h40);
        wr(1'b1, 8'h10);
        chk(irq == 1'b0, "R7 irq off after ie clear", irq, 0);
        cyc(2);
        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule